// File: doc/BRIEF.md
# 64-bit Bit-Manipulation Integer ALU

This block is the single-cycle integer arithmetic and logic stage of a 64-bit core. It takes two 64-bit operands, a 7-bit operation code and a valid flag. It returns one registered 64-bit result and a matching valid flag one clock later. The three upper opcode bits pick a family of operations:

| Opcode[6:4] | Family |
|---|---|
| 000 | full-width shifts, rotates and single-bit operations |
| 001 | 32-bit word operations |
| 010 | add variants |
| 011 | subtract and compare |
| 100, 101 | logic, extension, packing and byte permutation |
| 110 | logic results reduced to one bit or to a zero-extended halfword |

Besides the usual set, it provides several fused operations:

- adds of an operand pre-shifted right by 29 to 32 places;
- an add that uses only bit 0 of the first operand;
- construction of a 32-bit upper-immediate constant from the second operand;
- word adds narrowed to a bit, a byte or a halfword;
- logic operations reduced to a single bit.

Decoding of the instruction into the opcode happens upstream. Branch resolution, multiply and divide are handled elsewhere.

Top module: `bitmanip_alu`

## Requirements
- R1: While reset is held and after its release with no valid input, outValid is 0 and result is 0.
- R2: outValid equals inValid of the previous clock edge. result is loaded only on an edge where inValid is 1, and otherwise keeps its value.
- R3: Full-width shifts take the amount from src2[5:0]:
  - 0000001 is a logical left shift.
  - 0000101 is a logical right shift.
  - 0000111 is an arithmetic right shift.
  - 0000000 left-shifts the zero-extended src1[31:0].
  - 0001001 rotates left and 0001011 rotates right.
- R4: Single-bit operations index with src2[5:0]:
  - 0000010 clears the indexed bit.
  - 0000011 sets the indexed bit.
  - 0000100 returns src1 XOR (1 << index).
  - 0000110 returns the indexed bit of src1 in bit 0 with all other bits zero.
- R5: Word operations give a 32-bit value sign-extended from bit 31:
  - 0010000 is src1+src2.
  - 0010010 is src1-src2.
  - 0011000 shifts left and 0011001 shifts src1[31:0] logically right.
  - 0011010 shifts src1[31:0] arithmetically right.
  - 0011100 and 0011101 rotate src1[31:0] left and right.
  - Shift and rotate amounts come from src2[4:0].
- R6: Narrowed word adds of s = src1+src2:
  - 0010100 gives s[0].
  - 0010101 gives s[7:0].
  - 0010110 gives s[15:0] zero-extended.
  - 0010111 gives s[15:0] sign-extended.
- R7: Add variants:
  - 0100001 is src1+src2.
  - 0100000 is zero-extended src1[31:0] plus src2.
  - 0100010 is src1[0] plus src2.
  - 0010001 is that last sum sign-extended from bit 31.
- R8: 0100011 returns sign-extended src2[11:0] plus src2 with its low 12 bits cleared. 0010011 returns that sum sign-extended from bit 31.
- R9: Opcodes 0100100, 0100101, 0100110 and 0100111 return (src1 >> k) + src2 for k = 29, 30, 31 and 32 respectively, with a logical shift.
- R10: Shift-and-add returns (x << n) + src2:
  - 0101001, 0101011, 0101101 and 0101111 use x = src1 with n = 1, 2, 3 and 4.
  - 0101000, 0101010 and 0101100 use x = zero-extended src1[31:0] with n = 1, 2 and 3.
- R11: Subtract and compare:
  - 0110000 is src1-src2.
  - 0110001 is unsigned less-than (0 or 1).
  - 0110010 is signed less-than (0 or 1).
  - 0110100, 0110101, 0110110 and 0110111 are unsigned max, unsigned min, signed max and signed min.
- R12: Logic, extension and packing:
  - 1000000 is AND, 1000001 is src1 AND NOT src2.
  - 1000010 is OR, 1000011 is src1 OR NOT src2.
  - 1000100 is XOR, 1000101 is XNOR.
  - 1000110 sets each byte of src1 to FF if it is nonzero, else 00.
  - 1001000 sign-extends src1[7:0] and 1001010 sign-extends src1[15:0].
  - 1001001 is {48'b0, src2[7:0], src1[7:0]}.
  - 1001011 is {src2[15:0], src1[15:0]} sign-extended from bit 31.
- R13: Byte permutation and the fallback case:
  - 1010000 reverses the bit order inside each byte of src1.
  - 1010001 reverses the byte order of src1.
  - 1010010 is {src2[31:0], src1[31:0]}.
  - Every opcode not listed in these requirements yields 0.
- R14: Opcodes 1100xyz apply a logic operation chosen by xy: 00 AND, 01 OR, 10 XOR, 11 the per-byte OR-combine of src1. z = 0 keeps only bit 0 of the result. z = 1 keeps bits [15:0], zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands and opcode are valid this cycle |
| opcode | input | 7 | Operation code |
| src1 | input | 64 | First operand |
| src2 | input | 64 | Second operand |
| outValid | output | 1 | Result register holds a fresh result |
| result | output | 64 | Registered result |

## Verification
Each result is due exactly one rising edge after the cycle that presents it with inValid high. The same edge raises outValid, so the bench drives stimulus on a falling edge and compares on the next falling edge. Every valid cycle is followed by an idle cycle with disturbed operands and opcode, and the output is checked again one edge later. That check confirms outValid has dropped and the result has been held. All 128 opcodes are swept over eight operand pairs chosen to hit sign bits, shift amounts of 0, 31, 37 and 63, carries across bit 31 and immediate sign bits.

// File: rtl/bmalu_pkg.sv
package bmalu_pkg;

  localparam int OPW = 7;

  typedef enum logic [2:0] {
    U_NONE, U_SHIFT, U_BIT, U_ADD, U_CMP, U_LOGIC
  } unit_e;

  typedef enum logic [2:0] {
    SK_SLL, SK_SRL, SK_SRA, SK_ROL, SK_ROR
  } shift_e;

  typedef enum logic [1:0] {
    BK_CLR, BK_SET, BK_INV, BK_EXT
  } bit_e;

  typedef enum logic [2:0] {
    CK_LTU, CK_LTS, CK_MAXU, CK_MINU, CK_MAX, CK_MIN
  } cmp_e;

  typedef enum logic [3:0] {
    LK_AND, LK_ANDN, LK_OR, LK_ORN, LK_XOR, LK_XNOR, LK_ORCB,
    LK_SEXTB, LK_SEXTH, LK_PACKH, LK_PACKW, LK_BREV8, LK_REV8, LK_PACK
  } logic_e;

  // first-operand conditioning ahead of the shifter and adder
  typedef enum logic [1:0] {
    P_PLAIN, P_ZEXT32, P_BIT0, P_SRIGHT
  } pre_e;

  // final narrowing of the selected unit output
  typedef enum logic [2:0] {
    N_NONE, N_SEXT32, N_BIT0, N_BYTE, N_ZEXTH, N_SEXTH
  } narrow_e;

  typedef struct packed {
    unit_e   unit;
    shift_e  shiftK;
    bit_e    bitK;
    cmp_e    cmpK;
    logic_e  logicK;
    pre_e    pre;
    logic [2:0] addShl;
    logic [5:0] srAmt;
    logic    lui;
    logic    sub;
    logic    word;
    narrow_e narrow;
  } alu_ctrl_t;

endpackage

// File: rtl/bmalu_ctrl.sv
module bmalu_ctrl
  import bmalu_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  output alu_ctrl_t      ctl
);

  always_comb begin
    ctl = '0;
    casez (opcode)
      // family 000: full-width shifts and single-bit ops
      7'b000_0000: begin ctl.unit = U_SHIFT; ctl.shiftK = SK_SLL; ctl.pre = P_ZEXT32; end
      7'b000_0001: begin ctl.unit = U_SHIFT; ctl.shiftK = SK_SLL; end
      7'b000_0101: begin ctl.unit = U_SHIFT; ctl.shiftK = SK_SRL; end
      7'b000_0111: begin ctl.unit = U_SHIFT; ctl.shiftK = SK_SRA; end
      7'b000_1001: begin ctl.unit = U_SHIFT; ctl.shiftK = SK_ROL; end
      7'b000_1011: begin ctl.unit = U_SHIFT; ctl.shiftK = SK_ROR; end
      7'b000_0010: begin ctl.unit = U_BIT; ctl.bitK = BK_CLR; end
      7'b000_0011: begin ctl.unit = U_BIT; ctl.bitK = BK_SET; end
      7'b000_0100: begin ctl.unit = U_BIT; ctl.bitK = BK_INV; end
      7'b000_0110: begin ctl.unit = U_BIT; ctl.bitK = BK_EXT; end
      // family 001: word ops
      7'b001_0000: begin ctl.unit = U_ADD; ctl.narrow = N_SEXT32; end
      7'b001_0001: begin ctl.unit = U_ADD; ctl.pre = P_BIT0; ctl.narrow = N_SEXT32; end
      7'b001_0010: begin ctl.unit = U_ADD; ctl.sub = 1'b1; ctl.narrow = N_SEXT32; end
      7'b001_0011: begin ctl.unit = U_ADD; ctl.lui = 1'b1; ctl.narrow = N_SEXT32; end
      7'b001_0100: begin ctl.unit = U_ADD; ctl.narrow = N_BIT0; end
      7'b001_0101: begin ctl.unit = U_ADD; ctl.narrow = N_BYTE; end
      7'b001_0110: begin ctl.unit = U_ADD; ctl.narrow = N_ZEXTH; end
      7'b001_0111: begin ctl.unit = U_ADD; ctl.narrow = N_SEXTH; end
      7'b001_1000: begin ctl.unit = U_SHIFT; ctl.shiftK = SK_SLL; ctl.word = 1'b1; ctl.narrow = N_SEXT32; end
      7'b001_1001: begin ctl.unit = U_SHIFT; ctl.shiftK = SK_SRL; ctl.word = 1'b1; ctl.narrow = N_SEXT32; end
      7'b001_1010: begin ctl.unit = U_SHIFT; ctl.shiftK = SK_SRA; ctl.word = 1'b1; ctl.narrow = N_SEXT32; end
      7'b001_1100: begin ctl.unit = U_SHIFT; ctl.shiftK = SK_ROL; ctl.word = 1'b1; ctl.narrow = N_SEXT32; end
      7'b001_1101: begin ctl.unit = U_SHIFT; ctl.shiftK = SK_ROR; ctl.word = 1'b1; ctl.narrow = N_SEXT32; end
      // family 010: add variants
      7'b010_0000: begin ctl.unit = U_ADD; ctl.pre = P_ZEXT32; end
      7'b010_0001: begin ctl.unit = U_ADD; end
      7'b010_0010: begin ctl.unit = U_ADD; ctl.pre = P_BIT0; end
      7'b010_0011: begin ctl.unit = U_ADD; ctl.lui = 1'b1; end
      7'b010_01??: begin
        ctl.unit  = U_ADD;
        ctl.pre   = P_SRIGHT;
        ctl.srAmt = 6'd29 + {4'd0, opcode[1:0]};
      end
      7'b010_1???: begin
        if (opcode[2:0] == 3'b111) begin
          ctl.unit   = U_ADD;
          ctl.addShl = 3'd4;
        end else if (opcode[2:0] != 3'b110) begin
          ctl.unit   = U_ADD;
          ctl.addShl = {1'b0, opcode[2:1]} + 3'd1;
          ctl.pre    = opcode[0] ? P_PLAIN : P_ZEXT32;
        end
      end
      // family 011: subtract and compare
      7'b011_0000: begin ctl.unit = U_ADD; ctl.sub = 1'b1; end
      7'b011_0001: begin ctl.unit = U_CMP; ctl.cmpK = CK_LTU; end
      7'b011_0010: begin ctl.unit = U_CMP; ctl.cmpK = CK_LTS; end
      7'b011_0100: begin ctl.unit = U_CMP; ctl.cmpK = CK_MAXU; end
      7'b011_0101: begin ctl.unit = U_CMP; ctl.cmpK = CK_MINU; end
      7'b011_0110: begin ctl.unit = U_CMP; ctl.cmpK = CK_MAX; end
      7'b011_0111: begin ctl.unit = U_CMP; ctl.cmpK = CK_MIN; end
      // families 100 and 101: logic, extension, pack, permutation
      7'b100_0000: begin ctl.unit = U_LOGIC; ctl.logicK = LK_AND; end
      7'b100_0001: begin ctl.unit = U_LOGIC; ctl.logicK = LK_ANDN; end
      7'b100_0010: begin ctl.unit = U_LOGIC; ctl.logicK = LK_OR; end
      7'b100_0011: begin ctl.unit = U_LOGIC; ctl.logicK = LK_ORN; end
      7'b100_0100: begin ctl.unit = U_LOGIC; ctl.logicK = LK_XOR; end
      7'b100_0101: begin ctl.unit = U_LOGIC; ctl.logicK = LK_XNOR; end
      7'b100_0110: begin ctl.unit = U_LOGIC; ctl.logicK = LK_ORCB; end
      7'b100_1000: begin ctl.unit = U_LOGIC; ctl.logicK = LK_SEXTB; end
      7'b100_1001: begin ctl.unit = U_LOGIC; ctl.logicK = LK_PACKH; end
      7'b100_1010: begin ctl.unit = U_LOGIC; ctl.logicK = LK_SEXTH; end
      7'b100_1011: begin ctl.unit = U_LOGIC; ctl.logicK = LK_PACKW; ctl.narrow = N_SEXT32; end
      7'b101_0000: begin ctl.unit = U_LOGIC; ctl.logicK = LK_BREV8; end
      7'b101_0001: begin ctl.unit = U_LOGIC; ctl.logicK = LK_REV8; end
      7'b101_0010: begin ctl.unit = U_LOGIC; ctl.logicK = LK_PACK; end
      // family 110: reduced logic
      7'b110_0???: begin
        ctl.unit = U_LOGIC;
        case (opcode[2:1])
          2'b00:   ctl.logicK = LK_AND;
          2'b01:   ctl.logicK = LK_OR;
          2'b10:   ctl.logicK = LK_XOR;
          default: ctl.logicK = LK_ORCB;
        endcase
        ctl.narrow = opcode[0] ? N_ZEXTH : N_BIT0;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/bmalu_datapath.sv
module bmalu_datapath
  import bmalu_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  alu_ctrl_t    ctl,
  input  logic [W-1:0] src1,
  input  logic [W-1:0] src2,
  output logic         outValid,
  output logic [W-1:0] result
);

  localparam int HW  = W / 2;
  localparam int NB  = W / 8;
  localparam int SHW = $clog2(W);

  logic [W-1:0]     opA;
  logic [SHW-1:0]   amt;
  logic [SHW-2:0]   amtW;
  logic [W-1:0]     shIn, rol64, ror64, shRes;
  logic [HW-1:0]    x32, rol32, ror32;
  logic [W-1:0]     bitMask, bitRes;
  logic [W-1:0]     addA, addB, addRes;
  logic             ltu, lts;
  logic [W-1:0]     cmpRes;
  logic [W-1:0]     orcbV, rev8V, brev8V, logicRes;
  logic [W-1:0]     raw, narrowed;

  // first-operand conditioning
  always_comb begin
    case (ctl.pre)
      P_ZEXT32: opA = {{HW{1'b0}}, src1[HW-1:0]};
      P_BIT0:   opA = {{(W-1){1'b0}}, src1[0]};
      P_SRIGHT: opA = src1 >> ctl.srAmt;
      default:  opA = src1;
    endcase
  end

  // shifter and rotator
  assign amtW = src2[SHW-2:0];
  assign amt  = ctl.word ? {1'b0, amtW} : src2[SHW-1:0];
  assign x32  = src1[HW-1:0];

  always_comb begin
    if (ctl.word)
      shIn = (ctl.shiftK == SK_SRA) ? {{HW{src1[HW-1]}}, src1[HW-1:0]}
                                    : {{HW{1'b0}}, src1[HW-1:0]};
    else
      shIn = opA;
  end

  assign rol64 = (opA << amt) | (opA >> (W - amt));
  assign ror64 = (opA >> amt) | (opA << (W - amt));
  assign rol32 = (x32 << amtW) | (x32 >> (HW - amtW));
  assign ror32 = (x32 >> amtW) | (x32 << (HW - amtW));

  always_comb begin
    case (ctl.shiftK)
      SK_SLL:  shRes = shIn << amt;
      SK_SRL:  shRes = shIn >> amt;
      SK_SRA:  shRes = $signed(shIn) >>> amt;
      SK_ROL:  shRes = ctl.word ? {{HW{1'b0}}, rol32} : rol64;
      default: shRes = ctl.word ? {{HW{1'b0}}, ror32} : ror64;
    endcase
  end

  // single-bit unit
  assign bitMask = {{(W-1){1'b0}}, 1'b1} << src2[SHW-1:0];

  always_comb begin
    case (ctl.bitK)
      BK_CLR:  bitRes = src1 & ~bitMask;
      BK_SET:  bitRes = src1 | bitMask;
      BK_INV:  bitRes = src1 ^ bitMask;
      default: bitRes = {{(W-1){1'b0}}, |(src1 & bitMask)};
    endcase
  end

  // adder with pre-shift and upper-immediate build
  assign addA   = ctl.lui ? {{(W-12){src2[11]}}, src2[11:0]} : (opA << ctl.addShl);
  assign addB   = ctl.lui ? {src2[W-1:12], 12'b0} : src2;
  assign addRes = ctl.sub ? (addA - addB) : (addA + addB);

  // compare unit
  assign ltu = src1 < src2;
  assign lts = $signed(src1) < $signed(src2);

  always_comb begin
    case (ctl.cmpK)
      CK_LTU:  cmpRes = {{(W-1){1'b0}}, ltu};
      CK_LTS:  cmpRes = {{(W-1){1'b0}}, lts};
      CK_MAXU: cmpRes = ltu ? src2 : src1;
      CK_MINU: cmpRes = ltu ? src1 : src2;
      CK_MAX:  cmpRes = lts ? src2 : src1;
      default: cmpRes = lts ? src1 : src2;
    endcase
  end

  // byte-wise permutations
  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign orcbV[8*g +: 8] = {8{|src1[8*g +: 8]}};
    assign rev8V[8*g +: 8] = src1[W-8-8*g +: 8];
    for (genvar j = 0; j < 8; j++) begin : g_bit
      assign brev8V[8*g + j] = src1[8*g + 7 - j];
    end
  end

  always_comb begin
    case (ctl.logicK)
      LK_AND:   logicRes = src1 & src2;
      LK_ANDN:  logicRes = src1 & ~src2;
      LK_OR:    logicRes = src1 | src2;
      LK_ORN:   logicRes = src1 | ~src2;
      LK_XOR:   logicRes = src1 ^ src2;
      LK_XNOR:  logicRes = ~(src1 ^ src2);
      LK_ORCB:  logicRes = orcbV;
      LK_SEXTB: logicRes = {{(W-8){src1[7]}}, src1[7:0]};
      LK_SEXTH: logicRes = {{(W-16){src1[15]}}, src1[15:0]};
      LK_PACKH: logicRes = {{(W-16){1'b0}}, src2[7:0], src1[7:0]};
      LK_PACKW: logicRes = {{HW{1'b0}}, src2[15:0], src1[15:0]};
      LK_BREV8: logicRes = brev8V;
      LK_REV8:  logicRes = rev8V;
      default:  logicRes = {src2[HW-1:0], src1[HW-1:0]};
    endcase
  end

  // unit select and narrowing
  always_comb begin
    case (ctl.unit)
      U_SHIFT: raw = shRes;
      U_BIT:   raw = bitRes;
      U_ADD:   raw = addRes;
      U_CMP:   raw = cmpRes;
      U_LOGIC: raw = logicRes;
      default: raw = '0;
    endcase
    case (ctl.narrow)
      N_SEXT32: narrowed = {{HW{raw[HW-1]}}, raw[HW-1:0]};
      N_BIT0:   narrowed = {{(W-1){1'b0}}, raw[0]};
      N_BYTE:   narrowed = {{(W-8){1'b0}}, raw[7:0]};
      N_ZEXTH:  narrowed = {{(W-16){1'b0}}, raw[15:0]};
      N_SEXTH:  narrowed = {{(W-16){raw[15]}}, raw[15:0]};
      default:  narrowed = raw;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) result <= narrowed;
    end
  end

endmodule

// File: rtl/bitmanip_alu.sv
module bitmanip_alu
  import bmalu_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [6:0]   opcode,
  input  logic [W-1:0] src1,
  input  logic [W-1:0] src2,
  output logic         outValid,
  output logic [W-1:0] result
);

  alu_ctrl_t ctl;

  bmalu_ctrl u_ctrl (
    .opcode (opcode),
    .ctl    (ctl)
  );

  bmalu_datapath #(.W(W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctl      (ctl),
    .src1     (src1),
    .src2     (src2),
    .outValid (outValid),
    .result   (result)
  );

endmodule

// File: rtl/bmalu_checker.sv
module bmalu_checker #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic [6:0]   opcode,
  input logic [W-1:0] src1,
  input logic [W-1:0] src2,
  input logic         outValid,
  input logic [W-1:0] result
);

  localparam int HW = W / 2;

  p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result));

  p_plain_add_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode == 7'b010_0001) |=> result == $past(src1 + src2));

  p_extract_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode == 7'b000_0110) |=>
      result == ($past(src1 >> src2[5:0]) & {{(W-1){1'b0}}, 1'b1}));

  p_word_sext_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opcode == 7'b001_0000 || opcode == 7'b001_0010 ||
                 opcode == 7'b001_1000 || opcode == 7'b001_1001 ||
                 opcode == 7'b001_1010 || opcode == 7'b001_1100 ||
                 opcode == 7'b001_1101)) |=>
      result[W-1:HW] == {HW{result[HW-1]}});

  p_reduce_bit_r14: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode[6:3] == 4'b1100 && !opcode[0]) |=> result[W-1:1] == '0);

  p_reduce_half_r14: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode[6:3] == 4'b1100 && opcode[0]) |=> result[W-1:16] == '0);

endmodule

bind bitmanip_alu bmalu_checker #(.W(W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opcode   (opcode),
  .src1     (src1),
  .src2     (src2),
  .outValid (outValid),
  .result   (result)
);

// File: tb/bitmanip_alu_test.sv
`timescale 1ns/1ps
module bitmanip_alu_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [6:0]  opcode = '0;
  logic [63:0] src1 = '0;
  logic [63:0] src2 = '0;
  logic        outValid;
  logic [63:0] result;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  bitmanip_alu uut (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opcode   (opcode),
    .src1     (src1),
    .src2     (src2),
    .outValid (outValid),
    .result   (result)
  );

  function automatic logic [63:0] sx32(input logic [63:0] x);
    return {{32{x[31]}}, x[31:0]};
  endfunction

  function automatic logic [63:0] orcbOf(input logic [63:0] x);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = (x[8*i +: 8] != 8'h00) ? 8'hFF : 8'h00;
    return r;
  endfunction

  function automatic logic [63:0] model(input logic [6:0] op,
                                        input logic [63:0] a,
                                        input logic [63:0] b);
    logic [63:0] r, s, z;
    logic [31:0] w;
    logic signed [31:0] ws;
    z = {32'b0, a[31:0]};
    s = a + b;
    r = '0;
    case (op)
      7'h00: r = z << b[5:0];
      7'h01: r = a << b[5:0];
      7'h05: r = a >> b[5:0];
      7'h07: r = $signed(a) >>> b[5:0];
      7'h09: begin r = a; for (int i = 0; i < int'(b[5:0]); i++) r = {r[62:0], r[63]}; end
      7'h0B: begin r = a; for (int i = 0; i < int'(b[5:0]); i++) r = {r[0], r[63:1]}; end
      7'h02: r = a & ~(64'd1 << b[5:0]);
      7'h03: r = a | (64'd1 << b[5:0]);
      7'h04: r = a ^ (64'd1 << b[5:0]);
      7'h06: r = {63'b0, a[b[5:0]]};
      7'h10: r = sx32(s);
      7'h11: r = sx32({63'b0, a[0]} + b);
      7'h12: r = sx32(a - b);
      7'h13: r = sx32({{52{b[11]}}, b[11:0]} + (b & ~64'hFFF));
      7'h14: r = {63'b0, s[0]};
      7'h15: r = {56'b0, s[7:0]};
      7'h16: r = {48'b0, s[15:0]};
      7'h17: r = {{48{s[15]}}, s[15:0]};
      7'h18: r = sx32(a << b[4:0]);
      7'h19: r = sx32(z >> b[4:0]);
      7'h1A: begin ws = a[31:0]; ws = ws >>> b[4:0]; r = sx32({32'b0, ws}); end
      7'h1C: begin w = a[31:0]; for (int i = 0; i < int'(b[4:0]); i++) w = {w[30:0], w[31]}; r = sx32({32'b0, w}); end
      7'h1D: begin w = a[31:0]; for (int i = 0; i < int'(b[4:0]); i++) w = {w[0], w[31:1]}; r = sx32({32'b0, w}); end
      7'h20: r = z + b;
      7'h21: r = s;
      7'h22: r = {63'b0, a[0]} + b;
      7'h23: r = {{52{b[11]}}, b[11:0]} + (b & ~64'hFFF);
      7'h24: r = (a >> 29) + b;
      7'h25: r = (a >> 30) + b;
      7'h26: r = (a >> 31) + b;
      7'h27: r = (a >> 32) + b;
      7'h28: r = (z << 1) + b;
      7'h29: r = (a << 1) + b;
      7'h2A: r = (z << 2) + b;
      7'h2B: r = (a << 2) + b;
      7'h2C: r = (z << 3) + b;
      7'h2D: r = (a << 3) + b;
      7'h2F: r = (a << 4) + b;
      7'h30: r = a - b;
      7'h31: r = (a < b) ? 64'd1 : 64'd0;
      7'h32: r = ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
      7'h34: r = (a > b) ? a : b;
      7'h35: r = (a < b) ? a : b;
      7'h36: r = ($signed(a) > $signed(b)) ? a : b;
      7'h37: r = ($signed(a) < $signed(b)) ? a : b;
      7'h40: r = a & b;
      7'h41: r = a & ~b;
      7'h42: r = a | b;
      7'h43: r = a | ~b;
      7'h44: r = a ^ b;
      7'h45: r = ~(a ^ b);
      7'h46: r = orcbOf(a);
      7'h48: r = {{56{a[7]}}, a[7:0]};
      7'h49: r = {48'b0, b[7:0], a[7:0]};
      7'h4A: r = {{48{a[15]}}, a[15:0]};
      7'h4B: r = sx32({32'b0, b[15:0], a[15:0]});
      7'h50: for (int i = 0; i < 64; i++) r[i] = a[(i / 8) * 8 + 7 - (i % 8)];
      7'h51: for (int i = 0; i < 8; i++) r[8*i +: 8] = a[56 - 8*i +: 8];
      7'h52: r = {b[31:0], a[31:0]};
      7'h60: r = (a & b) & 64'h1;
      7'h61: r = (a & b) & 64'hFFFF;
      7'h62: r = (a | b) & 64'h1;
      7'h63: r = (a | b) & 64'hFFFF;
      7'h64: r = (a ^ b) & 64'h1;
      7'h65: r = (a ^ b) & 64'hFFFF;
      7'h66: r = orcbOf(a) & 64'h1;
      7'h67: r = orcbOf(a) & 64'hFFFF;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string reqOf(input logic [6:0] op);
    case (op)
      7'h00, 7'h01, 7'h05, 7'h07, 7'h09, 7'h0B: return "R3";
      7'h02, 7'h03, 7'h04, 7'h06: return "R4";
      7'h10, 7'h12, 7'h18, 7'h19, 7'h1A, 7'h1C, 7'h1D: return "R5";
      7'h14, 7'h15, 7'h16, 7'h17: return "R6";
      7'h11, 7'h20, 7'h21, 7'h22: return "R7";
      7'h13, 7'h23: return "R8";
      7'h24, 7'h25, 7'h26, 7'h27: return "R9";
      7'h28, 7'h29, 7'h2A, 7'h2B, 7'h2C, 7'h2D, 7'h2F: return "R10";
      7'h30, 7'h31, 7'h32, 7'h34, 7'h35, 7'h36, 7'h37: return "R11";
      7'h40, 7'h41, 7'h42, 7'h43, 7'h44, 7'h45, 7'h46,
      7'h48, 7'h49, 7'h4A, 7'h4B: return "R12";
      7'h60, 7'h61, 7'h62, 7'h63, 7'h64, 7'h65, 7'h66, 7'h67: return "R14";
      default: return "R13";
    endcase
  endfunction

  task automatic check(input string req, input logic [6:0] op,
                       input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s op=%b got=%h exp=%h", req, op, got, exp);
    end
  endtask

  logic [63:0] va [8];
  logic [63:0] vb [8];

  initial begin
    va[0] = 64'h0;                   vb[0] = 64'h0;
    va[1] = 64'hFFFF_FFFF_FFFF_FFFF; vb[1] = 64'h1;
    va[2] = 64'h8000_0000_8000_0001; vb[2] = 64'h3F;
    va[3] = 64'h0123_4567_89AB_CDEF; vb[3] = 64'hFEDC_BA98_7654_3210;
    va[4] = 64'h7FFF_FFFF_FFFF_FFFF; vb[4] = 64'h8000_0000_0000_0000;
    va[5] = 64'h0000_0000_FFFF_F800; vb[5] = 64'h0000_0000_1234_5FFF;
    va[6] = 64'hF0F0_0000_00FF_7F80; vb[6] = 64'h0000_0000_0000_0025;
    va[7] = 64'h00A5_0000_8000_0000; vb[7] = 64'hFFFF_FFFF_8000_081F;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", opcode, {63'b0, outValid}, 64'd0);
    check("R1", opcode, result, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", opcode, {63'b0, outValid}, 64'd0);
    check("R1", opcode, result, 64'd0);

    for (int v = 0; v < 8; v++) begin
      for (int o = 0; o < 128; o++) begin
        logic [63:0] exp;
        exp = model(7'(o), va[v], vb[v]);
        inValid = 1'b1;
        opcode  = 7'(o);
        src1    = va[v];
        src2    = vb[v];
        @(posedge clk);
        @(negedge clk);
        check(reqOf(7'(o)), 7'(o), result, exp);
        check("R2", 7'(o), {63'b0, outValid}, 64'd1);
        // idle cycle with disturbed inputs: result must hold
        inValid = 1'b0;
        opcode  = ~opcode;
        src1    = ~src1;
        src2    = src2 + 64'd7;
        @(posedge clk);
        @(negedge clk);
        check("R2", 7'(o), result, exp);
        check("R2", 7'(o), {63'b0, outValid}, 64'd0);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R2 got=timeout exp=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule